// File: doc/BRIEF.md
# Circular EEPROM Log Sequencer

This controller sits above a serial EEPROM byte-write master and treats the memory as a ring of bytes. A store request appends one data byte at the current write pointer. The pointer then advances, and it returns to zero once it reaches the memory size. An erase request starts a hardware sweep that writes zero to every location from address zero upward. When the sweep ends, all bookkeeping registers are cleared.

Each memory write goes to the master as one non-sequential byte write, over a request/done handshake. The sequencer raises its request and holds address and data steady until the master returns a single-cycle done pulse. The master performs its own acknowledge polling before it sends the address. The sequencer also keeps three registers and exposes them as status: the write pointer, a stored-byte counter, and a backup pointer that holds the address of the most recently stored byte.

Top module: `eelog_seq`

## Requirements
- R1: After reset the write pointer, stored-byte counter and backup pointer are zero, and busy, done and the master request are low.
- R2: An accepted store raises the master request with the master address equal to the current write pointer and the master data equal to the byte presented with the store request.
- R3: When the master done pulse ends a store, the write pointer and the stored-byte counter each increase by one.
- R4: The write pointer never exceeds MEM_DEPTH-1. A store at address MEM_DEPTH-1 sets the pointer back to 0, and the next store writes address 0.
- R5: An erase issues exactly MEM_DEPTH master writes, at addresses 0, 1, 2 … MEM_DEPTH-1 in ascending order, each with data zero.
- R6: When the last erase write completes, the write pointer, the stored-byte counter and the backup pointer are all zero.
- R7: Store and erase requests that arrive while busy is high are ignored: they cause no extra master write and no extra pointer or counter change.
- R8: If a store request and an erase request arrive in the same idle cycle, the erase is performed and the store is dropped.
- R9: The stored-byte counter is CNT_W bits wide (default 8). It keeps counting past MEM_DEPTH, so 129 stores after an erase give 129.
- R10: Busy goes high in the cycle after a request is accepted and stays high until the final master done pulse. In the following cycle done is high for exactly one clock and busy is low.
- R11: After each store, the backup pointer holds the address the byte was written to.
- R12: While the master request is high and done has not arrived, the master address and data do not change. Between successive erase writes the request drops for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| store_req | input | 1 | Append one byte (taken only when idle) |
| store_data | input | DATA_W | Byte to append |
| erase_req | input | 1 | Sweep the whole memory with zeros (taken only when idle) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| mst_req | output | 1 | Byte-write request to the EEPROM master |
| mst_addr | output | ADDR_W | Byte address for the master |
| mst_data | output | DATA_W | Byte value for the master |
| mst_done | input | 1 | One-cycle completion pulse from the master |
| wr_ptr | output | ADDR_W | Current write pointer |
| stored_cnt | output | CNT_W | Stored-byte counter |
| backup_ptr | output | ADDR_W | Address of the last stored byte |

## Verification
The bench builds the block with its default values: MEM_DEPTH of 128, 8-bit data and an 8-bit counter. With these values a full wrap of the pointer and a counter value above 128 can both be reached in a few hundred stores. Because 128 is a power of two, the default build uses the pointer variant that wraps naturally. The full 128-step erase sweep is checked address by address against a log kept by the master model.

// File: rtl/eelog_pkg.sv
package eelog_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_GAP   = 2'd2
   } seq_state_t;

   typedef enum logic {
      OP_STORE = 1'b0,
      OP_ERASE = 1'b1
   } seq_op_t;
endpackage

// File: rtl/eelog_ptr.sv
module eelog_ptr #(
   parameter int MEM_DEPTH = 128,
   parameter int ADDR_W    = 7
) (
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] nxt,
   output logic              last
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(MEM_DEPTH - 1);
   localparam bit IS_POW2 = (MEM_DEPTH & (MEM_DEPTH - 1)) == 0;

   assign last = (cur == TOP_ADDR);

   generate
      if (IS_POW2) begin : g_natural_wrap
         assign nxt = cur + 1'b1;
      end else begin : g_compare_wrap
         assign nxt = last ? '0 : cur + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/eelog_fsm.sv
module eelog_fsm
   import eelog_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic store_req,
   input  logic erase_req,
   input  logic mst_done,
   input  logic sweep_last,
   output logic busy,
   output logic mst_req,
   output logic erasing,
   output logic start_store,
   output logic start_erase,
   output logic step,
   output logic done
);
   seq_state_t state_q;
   seq_op_t    op_q;
   logic       finish;

   assign busy        = (state_q != ST_IDLE);
   assign mst_req     = (state_q == ST_WRITE);
   assign erasing     = busy && (op_q == OP_ERASE);
   assign start_erase = (state_q == ST_IDLE) && erase_req;
   assign start_store = (state_q == ST_IDLE) && store_req && !erase_req;
   assign step        = (state_q == ST_WRITE) && mst_done;
   assign finish      = step && ((op_q == OP_STORE) || sweep_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_STORE;
         done    <= 1'b0;
      end else begin
         done <= finish;
         unique case (state_q)
            ST_IDLE: begin
               if (start_erase) begin
                  state_q <= ST_WRITE;
                  op_q    <= OP_ERASE;
               end else if (start_store) begin
                  state_q <= ST_WRITE;
                  op_q    <= OP_STORE;
               end
            end
            ST_WRITE: begin
               if (finish)    state_q <= ST_IDLE;
               else if (step) state_q <= ST_GAP;
            end
            ST_GAP:  state_q <= ST_WRITE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r12_gap_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !finish) |=> !mst_req);
endmodule

// File: rtl/eelog_seq.sv
module eelog_seq #(
   parameter int MEM_DEPTH = 128,
   parameter int DATA_W    = 8,
   parameter int CNT_W     = 8,
   localparam int ADDR_W   = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_req,
   input  logic [DATA_W-1:0] store_data,
   input  logic              erase_req,
   output logic              busy,
   output logic              done,
   output logic              mst_req,
   output logic [ADDR_W-1:0] mst_addr,
   output logic [DATA_W-1:0] mst_data,
   input  logic              mst_done,
   output logic [ADDR_W-1:0] wr_ptr,
   output logic [CNT_W-1:0]  stored_cnt,
   output logic [ADDR_W-1:0] backup_ptr
);
   initial begin : p_param_check
      assert (MEM_DEPTH >= 2) else $error("MEM_DEPTH must be at least 2");
      assert (DATA_W >= 1)    else $error("DATA_W must be positive");
      assert (CNT_W >= 1)     else $error("CNT_W must be positive");
   end

   logic              erasing, start_store, start_erase, step, sweep_last;
   logic [ADDR_W-1:0] ptr_q, ptr_nxt, backup_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] data_q;

   eelog_ptr #(.MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_ptr (
      .cur  (ptr_q),
      .nxt  (ptr_nxt),
      .last (sweep_last)
   );

   eelog_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .store_req   (store_req),
      .erase_req   (erase_req),
      .mst_done    (mst_done),
      .sweep_last  (sweep_last),
      .busy        (busy),
      .mst_req     (mst_req),
      .erasing     (erasing),
      .start_store (start_store),
      .start_erase (start_erase),
      .step        (step),
      .done        (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         backup_q <= '0;
         cnt_q    <= '0;
         data_q   <= '0;
      end else if (start_erase) begin
         ptr_q  <= '0;
         data_q <= '0;
      end else if (start_store) begin
         data_q <= store_data;
      end else if (step) begin
         ptr_q <= ptr_nxt;
         if (!erasing) begin
            cnt_q    <= cnt_q + 1'b1;
            backup_q <= ptr_q;
         end else if (sweep_last) begin
            cnt_q    <= '0;
            backup_q <= '0;
         end
      end
   end

   assign mst_addr   = ptr_q;
   assign mst_data   = data_q;
   assign wr_ptr     = ptr_q;
   assign stored_cnt = cnt_q;
   assign backup_ptr = backup_q;

   a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr <= ADDR_W'(MEM_DEPTH - 1));
   a_r5_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (erasing && mst_req) |-> (mst_data == '0));
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_req && !mst_done) |=> (mst_req && $stable(mst_addr) && $stable(mst_data)));
   a_r7_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mst_done) |=> ($stable(wr_ptr) && $stable(stored_cnt)));
   a_r6_erase_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (erasing && step && sweep_last) |=> (stored_cnt == '0 && backup_ptr == '0 && wr_ptr == '0));
endmodule

// File: tb/eelog_seq_test.sv
module eelog_seq_test;
   localparam int DEPTH = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       store_req = 1'b0;
   logic [7:0] store_data = 8'h00;
   logic       erase_req = 1'b0;
   logic       busy, done, mst_req, mst_done;
   logic [6:0] mst_addr, wr_ptr, backup_ptr;
   logic [7:0] mst_data, stored_cnt;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   int log_addr [0:1023];
   int log_data [0:1023];
   int log_n = 0;
   int wcnt = 0;

   always #5 clk = ~clk;

   eelog_seq uut (
      .clk(clk), .rst_n(rst_n), .store_req(store_req), .store_data(store_data),
      .erase_req(erase_req), .busy(busy), .done(done), .mst_req(mst_req),
      .mst_addr(mst_addr), .mst_data(mst_data), .mst_done(mst_done),
      .wr_ptr(wr_ptr), .stored_cnt(stored_cnt), .backup_ptr(backup_ptr)
   );

   // master model: done pulse three cycles into each request, logs each write
   initial mst_done = 1'b0;
   always @(posedge clk) begin
      mst_done <= 1'b0;
      if (mst_req && !mst_done) begin
         if (wcnt == 2) begin
            mst_done <= 1'b1;
            wcnt <= 0;
            if (log_n < 1024) begin
               log_addr[log_n] = int'(mst_addr);
               log_data[log_n] = int'(mst_data);
            end
            log_n <= log_n + 1;
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // wait for done; checks busy stays high until then (R10)
   task automatic wait_done();
      int n = 0;
      bit busy_ok = 1'b1;
      while (!done && n < 5000) begin
         if (!busy) busy_ok = 1'b0;
         @(negedge clk);
         n++;
      end
      chk(done, "R10 done seen", int'(done), 1);
      chk(busy_ok, "R10 busy held", int'(busy_ok), 1);
      chk(!busy, "R10 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk(!done, "R10 done one cycle", int'(done), 0);
   endtask

   task automatic do_store(input logic [7:0] d);
      int exp_ptr = (int'(wr_ptr) + 1) % DEPTH;
      int exp_cnt = (int'(stored_cnt) + 1) % 256;
      int exp_addr = int'(wr_ptr);
      int n0 = log_n;
      store_req = 1'b1;
      store_data = d;
      @(negedge clk);
      store_req = 1'b0;
      wait_done();
      chk(log_n == n0 + 1, "R2 one write", log_n - n0, 1);
      chk(log_addr[n0] == exp_addr, "R2 address", log_addr[n0], exp_addr);
      chk(log_data[n0] == int'(d), "R2 data", log_data[n0], int'(d));
      chk(int'(wr_ptr) == exp_ptr, "R3 R4 pointer", int'(wr_ptr), exp_ptr);
      chk(int'(stored_cnt) == exp_cnt, "R3 counter", int'(stored_cnt), exp_cnt);
      chk(int'(backup_ptr) == exp_addr, "R11 backup", int'(backup_ptr), exp_addr);
   endtask

   task automatic t_reset();
      chk(wr_ptr == 0, "R1 pointer", int'(wr_ptr), 0);
      chk(stored_cnt == 0, "R1 counter", int'(stored_cnt), 0);
      chk(backup_ptr == 0, "R1 backup", int'(backup_ptr), 0);
      chk(!busy && !done && !mst_req, "R1 controls", int'({busy, done, mst_req}), 0);
   endtask

   task automatic t_basic();
      do_store(8'hA5);
      do_store(8'h3C);
      do_store(8'hFF);
   endtask

   task automatic t_ignore_busy();
      int n0 = log_n;
      int p0 = int'(wr_ptr);
      store_req = 1'b1;
      store_data = 8'h5A;
      @(negedge clk);
      store_req = 1'b0;
      chk(busy, "R10 busy after accept", int'(busy), 1);
      // R7: requests while busy
      store_req = 1'b1;
      erase_req = 1'b1;
      store_data = 8'h77;
      @(negedge clk);
      @(negedge clk);
      store_req = 1'b0;
      erase_req = 1'b0;
      chk(mst_data == 8'h5A, "R7 data held", int'(mst_data), 'h5A);
      wait_done();
      repeat (8) @(negedge clk);
      chk(log_n == n0 + 1, "R7 no extra write", log_n - n0, 1);
      chk(int'(wr_ptr) == p0 + 1, "R7 pointer once", int'(wr_ptr), p0 + 1);
      chk(!busy, "R7 stays idle", int'(busy), 0);
   endtask

   task automatic t_erase_priority();
      int n0 = log_n;
      bit sweep_ok = 1'b1;
      store_req = 1'b1;
      erase_req = 1'b1;
      store_data = 8'h99;
      @(negedge clk);
      store_req = 1'b0;
      erase_req = 1'b0;
      wait_done();
      chk(log_n == n0 + DEPTH, "R5 write count", log_n - n0, DEPTH);
      chk(log_data[n0] == 0, "R8 erase wins", log_data[n0], 0);
      for (int i = 0; i < DEPTH; i++) begin
         if (log_addr[n0 + i] != i || log_data[n0 + i] != 0) sweep_ok = 1'b0;
      end
      chk(sweep_ok, "R5 sweep order and zero", int'(sweep_ok), 1);
      chk(wr_ptr == 0, "R6 pointer", int'(wr_ptr), 0);
      chk(stored_cnt == 0, "R6 counter", int'(stored_cnt), 0);
      chk(backup_ptr == 0, "R6 backup", int'(backup_ptr), 0);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < DEPTH - 1; i++) do_store(8'(i + 1));
      chk(wr_ptr == 7'd127, "R4 at top", int'(wr_ptr), 127);
      do_store(8'hC3);
      chk(wr_ptr == 0, "R4 wrapped", int'(wr_ptr), 0);
      chk(backup_ptr == 7'd127, "R11 top backup", int'(backup_ptr), 127);
      do_store(8'h11);
      chk(stored_cnt == 8'd129, "R9 past depth", int'(stored_cnt), 129);
      chk(log_addr[log_n - 1] == 0, "R4 writes address 0", log_addr[log_n - 1], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_ignore_busy();
      t_erase_priority();
      t_wrap();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule